// File: doc/BRIEF.md
# Dual-Watermark Receive Packet FIFO

This block is a synchronous first-in first-out buffer for received frame data on a host system interface. Each entry holds one 32-bit word, the number of valid bytes in that word and a marker for the final word of a frame. A receive MAC path fills it. The host drains it one word per read enable.

Two registered level flags tell the host when to start draining. The first flag rises once the number of stored words exceeds a programmable threshold. The second flag uses its own threshold. It is also held high while any frame-ending word is stored, so that a short last frame below the threshold can still be drained. The oldest stored word is always present on the read outputs, so data is valid whenever either flag is high, whatever the state of the read enable.

Top module: `rx_wm_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the buffer, clears the stored frame-end count and drives `wm1`, `wm2` and `overflow` low.
- R2: `wm1` is 1 when the stored word count is greater than `thresh1`, and 0 when the count is less than or equal to `thresh1`.
- R3: `wm2` is 0 only when the stored word count is less than or equal to `thresh2` and no word tagged as frame end is stored. Otherwise `wm2` is 1.
- R4: Both flags are registers. After a clock edge they reflect the occupancy that results from the write and the read taken at that same edge.
- R5: While the buffer is not empty, `rd_data`, `rd_eof` and `rd_bytes` show the oldest stored entry without any read enable. A read enable at a clock edge advances them to the next entry.
- R6: Words leave in the order they were written, each with its own byte count (1 to 4) and frame-end tag unchanged.
- R7: The buffer accepts DEPTH words before it is full.
- R8: A write to a full buffer is dropped, even when a read happens in the same cycle. `overflow` is then 1 for exactly the one cycle that follows that edge.
- R9: A read enable on an empty buffer has no effect: the flags stay as they were and a later write is read back first.
- R10: When a frame-end word is written and a frame-end word is read at the same edge, the stored frame-end count does not change, and `wm2` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one entry |
| wr_data | input | DATA_W | Word to store |
| wr_eof | input | 1 | Word is the last of a frame |
| wr_bytes | input | BW | Valid bytes in the word (1 to 4) |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | DATA_W | Oldest stored word |
| rd_eof | output | 1 | Frame-end tag of the oldest entry |
| rd_bytes | output | BW | Byte count of the oldest entry |
| thresh1 | input | AW+1 | Threshold for `wm1` |
| thresh2 | input | AW+1 | Threshold for `wm2` |
| wm1 | output | 1 | Count above `thresh1` |
| wm2 | output | 1 | Count above `thresh2`, or a frame end stored |
| overflow | output | 1 | A write was dropped at the previous edge |

## Verification
Inputs change on the falling edge and results are sampled on the next falling edge. The flags, the overflow pulse and the head entry are all due one rising edge after the stimulus that causes them. The bench model applies each cycle's read and write at that same edge and compares against the state it holds afterwards. The head outputs are compared only while the model holds at least one entry. Thresholds change only between cycles, so the flags are judged against the values that were present at the edge.

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int BW = $clog2(DATA_W / 8) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic [BW-1:0]     wr_bytes,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eof,
  output logic [BW-1:0]     rd_bytes,
  input  logic [CW-1:0]     thresh1,
  input  logic [CW-1:0]     thresh2,
  output logic              wm1,
  output logic              wm2,
  output logic              overflow
);
  localparam int EW = DATA_W + BW + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, count_nx;
  logic [CW-1:0] eofs, eofs_nx;
  logic          full, empty, wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  assign {rd_eof, rd_bytes, rd_data} = mem[rp];

  assign count_nx = count + CW'(wr_ok) - CW'(rd_ok);
  assign eofs_nx  = eofs + CW'(wr_ok && wr_eof) - CW'(rd_ok && rd_eof);

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= {wr_eof, wr_bytes, wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      eofs     <= '0;
      wm1      <= 1'b0;
      wm2      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      count    <= count_nx;
      eofs     <= eofs_nx;
      wm1      <= count_nx > thresh1;
      wm2      <= (count_nx > thresh2) || (eofs_nx != '0);
      overflow <= wr_en && full;
    end
  end

  p_wm1_level_r2: assert property (@(posedge clk) disable iff (rst)
    $stable(thresh1) |-> (wm1 == (count > thresh1)));

  p_wm2_eof_r3: assert property (@(posedge clk) disable iff (rst)
    (eofs != '0) |-> wm2);

  p_wm2_low_r3: assert property (@(posedge clk) disable iff (rst)
    ($stable(thresh2) && !wm2) |-> (count <= thresh2 && eofs == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_drop_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && count == CW'(DEPTH)) |=> (overflow && count <= CW'(DEPTH)));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && count == '0) |=> (count == '0 && !wm1));

  p_eof_bound_r10: assert property (@(posedge clk) disable iff (rst)
    eofs <= count);
endmodule

// File: tb/rx_wm_fifo_test.sv
module rx_wm_fifo_test;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_eof = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [BW-1:0] wr_bytes = 3'd4;
  logic [CW-1:0] thresh1 = '0, thresh2 = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_eof, wm1, wm2, overflow;
  logic [BW-1:0] rd_bytes;

  rx_wm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
    .wr_bytes(wr_bytes), .rd_en(rd_en), .rd_data(rd_data), .rd_eof(rd_eof),
    .rd_bytes(rd_bytes), .thresh1(thresh1), .thresh2(thresh2), .wm1(wm1),
    .wm2(wm2), .overflow(overflow));

  always #10 clk = ~clk;

  logic [DATA_W+BW:0] q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  function automatic int eof_count();
    int n = 0;
    foreach (q[i]) if (q[i][DATA_W+BW]) n++;
    return n;
  endfunction

  function automatic bit exp_wm1();
    return q.size() > int'(thresh1);
  endfunction

  function automatic bit exp_wm2();
    return (q.size() > int'(thresh2)) || (eof_count() > 0);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit w, bit e, logic [BW-1:0] nb, logic [DATA_W-1:0] d, bit r, string tag);
    bit full_b, wok, rok;
    wr_en = w; wr_eof = e; wr_bytes = nb; wr_data = d; rd_en = r;
    full_b = q.size() == DEPTH;
    wok = w && !full_b;
    rok = r && q.size() > 0;
    if (rok) void'(q.pop_front());
    if (wok) q.push_back({e, nb, d});
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 wm1"}, 64'(wm1), 64'(exp_wm1()));
    chk({tag, " R3 wm2"}, 64'(wm2), 64'(exp_wm2()));
    chk({tag, " R8 overflow"}, 64'(overflow), 64'(w && full_b));
    if (q.size() > 0)
      chk({tag, " R6 head"}, 64'({rd_eof, rd_bytes, rd_data}), 64'(q[0]));
  endtask

  task automatic idle(string tag);
    step(0, 0, 3'd4, '0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wm1 after reset", 64'(wm1), 0);
    chk("R1 wm2 after reset", 64'(wm2), 0);
    chk("R1 overflow after reset", 64'(overflow), 0);

    // R9: read on empty
    thresh1 = 0; thresh2 = 0;
    step(0, 0, 3'd4, '0, 1, "R9 empty read");
    chk("R9 wm1 still low", 64'(wm1), 0);
    step(1, 0, 3'd2, 32'hA5A5_0001, 0, "R9 write after");
    chk("R9 first word", 64'(rd_data), 64'h A5A5_0001);
    step(0, 0, 3'd4, '0, 1, "R9 drain");

    // R4/R2 threshold crossing timing
    thresh1 = 2; thresh2 = 5;
    step(1, 0, 3'd4, 32'h11, 0, "R4 w1");
    step(1, 0, 3'd4, 32'h12, 0, "R4 w2");
    chk("R4 wm1 at count=thresh", 64'(wm1), 0);
    step(1, 0, 3'd4, 32'h13, 0, "R4 w3");
    chk("R4 wm1 one edge after crossing", 64'(wm1), 1);
    // R5: head shown without read
    chk("R5 head without rd_en", 64'(rd_data), 64'h11);
    step(0, 0, 3'd4, '0, 1, "R5 pop");
    chk("R5 head advanced", 64'(rd_data), 64'h12);
    chk("R2 wm1 back to low", 64'(wm1), 0);
    step(0, 0, 3'd4, '0, 1, "R5 pop2");
    step(0, 0, 3'd4, '0, 1, "R5 pop3");

    // R3/R10: eof keeps wm2 high, simultaneous eof in/out
    thresh1 = 15; thresh2 = 15;
    step(1, 1, 3'd1, 32'hE0F1, 0, "R3 eof write");
    chk("R3 wm2 with eof below thresh", 64'(wm2), 1);
    step(1, 1, 3'd3, 32'hE0F2, 1, "R10 eof in and out");
    chk("R10 wm2 held", 64'(wm2), 1);
    chk("R10 new head bytes", 64'(rd_bytes), 3);
    step(0, 0, 3'd4, '0, 1, "R10 drain");
    chk("R3 wm2 low when empty", 64'(wm2), 0);

    // R7/R8: fill to full, overflow, read+write while full
    thresh1 = 15; thresh2 = 16;
    for (int i = 0; i < DEPTH; i++) step(1, 0, 3'd4, 32'h100 + i, 0, "R7 fill");
    chk("R7 wm1 full", 64'(wm1), 1);
    chk("R7 overflow clear", 64'(overflow), 0);
    step(1, 0, 3'd4, 32'hDEAD, 0, "R8 drop");
    chk("R8 overflow pulse", 64'(overflow), 1);
    idle("R8 idle");
    chk("R8 overflow one cycle", 64'(overflow), 0);
    step(1, 0, 3'd4, 32'hBEEF, 1, "R8 drop with read");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 3'd4, '0, 1, "R6 drain");

    // random phase
    for (int blk = 0; blk < 12; blk++) begin
      int wp = 30 + int'($urandom_range(0, 50));
      thresh1 = CW'($urandom_range(0, DEPTH));
      thresh2 = CW'($urandom_range(0, DEPTH));
      idle("rand thresh");
      for (int c = 0; c < 250; c++) begin
        bit w = $urandom_range(0, 99) < wp;
        bit r = $urandom_range(0, 99) < 50;
        bit e = $urandom_range(0, 7) == 0;
        step(w, e, 3'($urandom_range(1, 4)), $urandom, r, "rand");
      end
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    chk("R1 wm2 after second reset", 64'(wm2), 0);
    chk("R1 wm1 after second reset", 64'(wm1), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule